// File: doc/BRIEF.md
# TDM Per-Channel Output Mode Selector

This block produces the byte stream for one serial time-division-multiplexed output, one 8-bit channel per timeslot. Each output timeslot owns one 16-bit word in a connection table. The word picks what the slot carries: a byte switched from the local or the backplane receive memory (with variable or constant throughput delay), a literal byte held in the word itself, a byte of a pseudo-random bit-error-rate test pattern, or nothing at all, with the output driver disabled.

Both receive sides write bytes into their own data memory. Each memory keeps two banks, one per frame parity, so that a whole frame of history stays available. An external counter supplies the current timeslot index and frame parity. The block looks one slot ahead: while slot `s-1` is current, it reads the table word for slot `s`, fetches the source byte and registers it, so the byte and its enable are steady for the whole of slot `s`. A processor port rewrites table words at any time.

Top module: `tdm_osel`

## Requirements
- R1: A table word is split as mode in bits 15..13, source stream in bits 12..8 and source channel in bits 7..0; only the low log2(STREAMS) stream bits and low log2(CHANNELS) channel bits address a data memory.
- R2: While reset is asserted `tx_oe` is 0 and `tx_data` is 8'hFF, and after reset every table word reads as mode 110, so no slot drives until it is programmed.
- R3: Mode 000 (variable delay, local) sends the local byte from the current-frame bank when the source channel is lower than the output slot, and otherwise from the previous-frame bank.
- R4: Mode 001 (constant delay, local) always sends the local byte from the previous-frame bank, which is one frame of delay.
- R5: Modes 010 and 011 behave as modes 000 and 001 respectively but read the backplane memory.
- R6: Mode 100 sends bits 7..0 of the table word with `tx_oe` = 1.
- R7: Mode 101 sends the next 8 bits of a PRBS with polynomial x^15+x^14+1: each step forms new = s[14]^s[13] and shifts it in at bit 0; the first new bit of a slot lands in `tx_data[7]`; the generator moves only in mode-101 slots.
- R8: When `frame_sync` and `prbs_clr` are both 1 in a cycle, the generator reloads all ones; the reload wins over an advance in that cycle, and a byte sent from that cycle still comes from the state before the reload.
- R9: Modes 110 and 111 give `tx_oe` = 0 and `tx_data` = 8'hFF.
- R10: The byte for slot s is registered at the end of the cycle in which `slot_idx` = s-1 (modulo CHANNELS) and holds for the cycle in which `slot_idx` = s; the slot after the last one is slot 0 and belongs to the next frame, whose parity is inverted.
- R11: A receive write lands in the bank given by `frame_par`; a read of the same bank, stream and channel in the same cycle returns the byte being written.
- R12: A table write is seen by reads in later cycles only; a read of that word in the same cycle returns the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-slot clock, one timeslot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_idx | input | log2(CHANNELS) | Current timeslot index |
| frame_par | input | 1 | Parity of the current frame |
| frame_sync | input | 1 | Frame-sync pulse |
| prbs_clr | input | 1 | Reload request for the test-pattern generator, sampled with `frame_sync` |
| loc_we | input | 1 | Local receive write strobe |
| loc_stream | input | log2(STREAMS) | Local write stream |
| loc_chan | input | log2(CHANNELS) | Local write channel |
| loc_data | input | 8 | Local write byte |
| bp_we | input | 1 | Backplane receive write strobe |
| bp_stream | input | log2(STREAMS) | Backplane write stream |
| bp_chan | input | log2(CHANNELS) | Backplane write channel |
| bp_data | input | 8 | Backplane write byte |
| cm_we | input | 1 | Table write strobe |
| cm_addr | input | log2(CHANNELS) | Table entry (output slot) to write |
| cm_wdata | input | 16 | Table word |
| tx_data | output | 8 | Output byte for the current slot |
| tx_oe | output | 1 | Output enable for the current slot |

## Verification
The hardest case is a variable-delay slot whose source channel is the slot directly before it, because the byte is written in the same cycle that the look-ahead reads it, so only forwarding gives the fresh value. The stimulus has both receive sides write channel c during slot c, the way a receiver fills its memory, and programs a few variable-delay slots with source channel equal to their own index minus one. A same-cycle table rewrite and a test-pattern reload on a frame-sync are placed at fixed slots, so the old table word and the restarted pattern show up in known output slots.

// File: rtl/tdm_osel_pkg.sv
package tdm_osel_pkg;

   typedef enum logic [2:0] {
      M_VAR_LOC = 3'b000,
      M_CON_LOC = 3'b001,
      M_VAR_BP  = 3'b010,
      M_CON_BP  = 3'b011,
      M_MSG     = 3'b100,
      M_PRBS    = 3'b101,
      M_HIZ     = 3'b110,
      M_RSVD    = 3'b111
   } osel_mode_e;

   typedef struct packed {
      osel_mode_e  mode;
      logic [4:0]  stream;
      logic [7:0]  chan;
   } cm_word_t;

   localparam logic [15:0] CM_RESET_WORD = 16'hC000;
   localparam logic [7:0]  IDLE_BYTE     = 8'hFF;

endpackage

// File: rtl/tdm_osel_dmem.sv
module tdm_osel_dmem #(
   parameter int STREAMS  = 4,
   parameter int CHANNELS = 32,
   parameter bit BYPASS   = 1'b1,
   localparam int SW      = $clog2(STREAMS),
   localparam int CW      = $clog2(CHANNELS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          wbank,
   input  logic [SW-1:0] wstream,
   input  logic [CW-1:0] wchan,
   input  logic [7:0]    wdata,
   input  logic          rbank,
   input  logic [SW-1:0] rstream,
   input  logic [CW-1:0] rchan,
   output logic [7:0]    rdata
);

   localparam int AW    = 1 + SW + CW;
   localparam int DEPTH = 1 << AW;

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] waddr;
   logic [AW-1:0] raddr;

   assign waddr = {wbank, wstream, wchan};
   assign raddr = {rbank, rstream, rchan};

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if (BYPASS) begin : g_fwd
         assign rdata = (we && (waddr == raddr)) ? wdata : mem[raddr];
      end else begin : g_plain
         assign rdata = mem[raddr];
      end
   endgenerate

   // R11: a write reaches the addressed bank location
   a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/tdm_osel_cmem.sv
module tdm_osel_cmem
   import tdm_osel_pkg::*;
#(
   parameter int CHANNELS = 32,
   localparam int CW      = $clog2(CHANNELS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [CW-1:0] waddr,
   input  logic [15:0]   wdata,
   input  logic [CW-1:0] raddr,
   output logic [15:0]   rdata
);

   logic [15:0] tbl [CHANNELS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < CHANNELS; i++) tbl[i] <= CM_RESET_WORD;
      end else if (we) begin
         tbl[waddr] <= wdata;
      end
   end

   assign rdata = tbl[raddr];

   // R12: a table write is visible from the next cycle on
   a_r12_cm_update: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (tbl[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/tdm_osel_prbs.sv
module tdm_osel_prbs #(
   parameter int ORDER = 15,
   parameter int TAP   = 14,
   parameter int BYTE  = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            adv,
   output logic [BYTE-1:0] byte_o
);

   logic [ORDER-1:0] state;
   logic [ORDER-1:0] stepped;

   always_comb begin
      logic [ORDER-1:0] s;
      logic             nb;
      s      = state;
      byte_o = '0;
      for (int i = 0; i < BYTE; i++) begin
         nb                 = s[ORDER-1] ^ s[TAP-1];
         byte_o[BYTE-1-i]   = nb;
         s                  = {s[ORDER-2:0], nb};
      end
      stepped = s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   state <= '1;
      else if (clr) state <= '1;
      else if (adv) state <= stepped;
   end

   // R7: a maximal-length register never reaches the lock-up state
   a_r7_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);
   // R7: the pattern moves only when a test slot asks for it
   a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !adv) |=> $stable(state));
   // R8: reload wins over advance
   a_r8_reload_ones: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (state == '1));

endmodule

// File: rtl/tdm_osel.sv
module tdm_osel
   import tdm_osel_pkg::*;
#(
   parameter int STREAMS   = 4,
   parameter int CHANNELS  = 32,
   parameter bit WR_BYPASS = 1'b1,
   localparam int SW       = $clog2(STREAMS),
   localparam int CW       = $clog2(CHANNELS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] slot_idx,
   input  logic          frame_par,
   input  logic          frame_sync,
   input  logic          prbs_clr,
   input  logic          loc_we,
   input  logic [SW-1:0] loc_stream,
   input  logic [CW-1:0] loc_chan,
   input  logic [7:0]    loc_data,
   input  logic          bp_we,
   input  logic [SW-1:0] bp_stream,
   input  logic [CW-1:0] bp_chan,
   input  logic [7:0]    bp_data,
   input  logic          cm_we,
   input  logic [CW-1:0] cm_addr,
   input  logic [15:0]   cm_wdata,
   output logic [7:0]    tx_data,
   output logic          tx_oe
);

   localparam logic [CW-1:0] LAST_SLOT = CW'(CHANNELS - 1);

   generate
      if (STREAMS < 2 || STREAMS > 32 || (STREAMS & (STREAMS - 1)) != 0) begin : g_bad_streams
         $error("STREAMS must be a power of two from 2 to 32");
      end
      if (CHANNELS < 2 || CHANNELS > 256 || (CHANNELS & (CHANNELS - 1)) != 0) begin : g_bad_channels
         $error("CHANNELS must be a power of two from 2 to 256");
      end
   endgenerate

   // look-ahead slot and the parity of the frame it belongs to
   logic [CW-1:0] nxt_slot;
   logic          nxt_par;
   assign nxt_slot = slot_idx + 1'b1;
   assign nxt_par  = frame_par ^ (slot_idx == LAST_SLOT);

   logic [15:0] cm_rd;
   cm_word_t    cw;

   tdm_osel_cmem #(.CHANNELS(CHANNELS)) u_cmem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cm_we),
      .waddr (cm_addr),
      .wdata (cm_wdata),
      .raddr (nxt_slot),
      .rdata (cm_rd)
   );

   assign cw = cm_word_t'(cm_rd);

   logic [SW-1:0] src_stream;
   logic [CW-1:0] src_chan;
   logic          src_early;
   logic          rd_bank;

   assign src_stream = SW'(cw.stream);
   assign src_chan   = CW'(cw.chan);
   assign src_early  = src_chan < nxt_slot;
   // even modes below 100 take variable delay; odd ones take the previous frame
   assign rd_bank    = (!cw.mode[0] && src_early) ? nxt_par : ~nxt_par;

   logic [7:0] loc_rd;
   logic [7:0] bp_rd;

   tdm_osel_dmem #(.STREAMS(STREAMS), .CHANNELS(CHANNELS), .BYPASS(WR_BYPASS)) u_loc_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (loc_we),
      .wbank   (frame_par),
      .wstream (loc_stream),
      .wchan   (loc_chan),
      .wdata   (loc_data),
      .rbank   (rd_bank),
      .rstream (src_stream),
      .rchan   (src_chan),
      .rdata   (loc_rd)
   );

   tdm_osel_dmem #(.STREAMS(STREAMS), .CHANNELS(CHANNELS), .BYPASS(WR_BYPASS)) u_bp_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bp_we),
      .wbank   (frame_par),
      .wstream (bp_stream),
      .wchan   (bp_chan),
      .wdata   (bp_data),
      .rbank   (rd_bank),
      .rstream (src_stream),
      .rchan   (src_chan),
      .rdata   (bp_rd)
   );

   logic       pat_adv;
   logic [7:0] pat_byte;

   assign pat_adv = (cw.mode == M_PRBS);

   tdm_osel_prbs #(.ORDER(15), .TAP(14), .BYTE(8)) u_prbs (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (frame_sync && prbs_clr),
      .adv    (pat_adv),
      .byte_o (pat_byte)
   );

   logic       nxt_oe;
   logic [7:0] nxt_byte;

   always_comb begin
      nxt_oe   = 1'b1;
      nxt_byte = IDLE_BYTE;
      unique case (cw.mode)
         M_VAR_LOC, M_CON_LOC: nxt_byte = loc_rd;
         M_VAR_BP,  M_CON_BP:  nxt_byte = bp_rd;
         M_MSG:                nxt_byte = cw.chan;
         M_PRBS:               nxt_byte = pat_byte;
         default:              nxt_oe   = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_oe   <= 1'b0;
         tx_data <= IDLE_BYTE;
      end else begin
         tx_oe   <= nxt_oe;
         tx_data <= nxt_oe ? nxt_byte : IDLE_BYTE;
      end
   end

   // R9: a disabled slot always shows the idle byte
   a_r9_idle_byte: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_oe |-> (tx_data == IDLE_BYTE));
   // R9: the high-impedance and reserved codes never drive
   a_r9_hiz_modes: assert property (@(posedge clk) disable iff (!rst_n)
      (cw.mode == M_HIZ || cw.mode == M_RSVD) |=> !tx_oe);
   // R6: a message slot carries the low byte of its word one slot later
   a_r6_msg_literal: assert property (@(posedge clk) disable iff (!rst_n)
      (cw.mode == M_MSG) |=> (tx_oe && tx_data == $past(cw.chan)));

endmodule

// File: tb/tdm_osel_test.sv
`timescale 1ns/1ps
module tdm_osel_test;

   localparam int ST = 4;
   localparam int CH = 32;
   localparam int SW = 2;
   localparam int CW = 5;
   localparam int NFRAMES = 7;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [CW-1:0] slot_idx = '0;
   logic          frame_par = 1'b0, frame_sync = 1'b0, prbs_clr = 1'b0;
   logic          loc_we = 1'b0, bp_we = 1'b0, cm_we = 1'b0;
   logic [SW-1:0] loc_stream = '0, bp_stream = '0;
   logic [CW-1:0] loc_chan = '0, bp_chan = '0, cm_addr = '0;
   logic [7:0]    loc_data = '0, bp_data = '0;
   logic [15:0]   cm_wdata = '0;
   logic [7:0]    tx_data;
   logic          tx_oe;

   tdm_osel #(.STREAMS(ST), .CHANNELS(CH)) uut (
      .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx), .frame_par(frame_par),
      .frame_sync(frame_sync), .prbs_clr(prbs_clr),
      .loc_we(loc_we), .loc_stream(loc_stream), .loc_chan(loc_chan), .loc_data(loc_data),
      .bp_we(bp_we), .bp_stream(bp_stream), .bp_chan(bp_chan), .bp_data(bp_data),
      .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata),
      .tx_data(tx_data), .tx_oe(tx_oe)
   );

   typedef struct {
      logic       oe;
      logic [7:0] d;
      string      tag;
      int         due;
   } exp_t;

   exp_t sb[$];
   int cyc = 0;
   int n_chk = 0, n_bad = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // reference model state
   logic [7:0]  lm [2][ST][CH];
   logic [7:0]  bm [2][ST][CH];
   logic [15:0] cm_m [CH];
   logic [14:0] lf = '1;
   bit          pat_fresh = 1'b0;

   task automatic check(string tag, logic aoe, logic [7:0] ad, logic eoe, logic [7:0] ed);
      n_chk++;
      if (aoe !== eoe || ad !== ed) begin
         n_bad++;
         $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h", tag, aoe, ad, eoe, ed);
      end
   endtask

   // monitor: R10, the byte pushed while slot s-1 is current is compared during slot s
   always @(negedge clk) begin : mon
      exp_t e;
      if (sb.size() > 0 && sb[0].due <= cyc) begin
         e = sb.pop_front();
         check(e.tag, tx_oe, tx_data, e.oe, e.d);
      end
   end

   function automatic logic [15:0] cm_word(int k);
      logic [7:0] chb;
      int ch;
      ch = (k * 11 + 3) % CH;
      if (k == 8 || k == 16 || k == 24) ch = k - 1;   // source is the slot just before (R11)
      chb = 8'(ch);
      case (k % 8)
         0: return {3'b000, 5'b11101, 8'hE0 | chb};    // stream field 29 -> stream 1 (R1)
         1: return {3'b001, 5'b11101, 8'hE0 | chb};
         2: return {3'b010, 5'b00010, chb};
         3: return {3'b011, 5'b00010, chb};
         4: return {3'b100, 5'b10110, 8'(k * 7 + 3)};
         5: return {3'b101, 13'h1ABC};
         6: return {3'b110, 13'h0F0F};
         default: return {3'b111, 13'h1234};
      endcase
   endfunction

   task automatic drive_cycle(int f, int c, bit fs, bit pclr, bit cwe, int caddr,
                              logic [15:0] cdat, string xtag);
      int nxt, bank, st, sc, op;
      logic [15:0] w;
      logic [2:0] md;
      logic [7:0] ld, bd, eb, pb;
      logic eoe;
      logic nb;
      string tag;
      exp_t e;
      @(posedge clk);
      #1;
      ld = 8'((f * 37 + c * 5 + 1) & 255);
      bd = 8'((f * 91 + c * 3 + 128) & 255);
      slot_idx = CW'(c); frame_par = f[0]; frame_sync = fs; prbs_clr = pclr;
      loc_we = 1'b1; loc_stream = 2'd1; loc_chan = CW'(c); loc_data = ld;
      bp_we = 1'b1; bp_stream = 2'd2; bp_chan = CW'(c); bp_data = bd;
      cm_we = cwe; cm_addr = CW'(caddr); cm_wdata = cdat;
      // R11: receive writes of this cycle are visible to this cycle's read
      lm[f % 2][1][c] = ld;
      bm[f % 2][2][c] = bd;
      nxt = (c + 1) % CH;
      op = (c == CH - 1) ? 1 - (f % 2) : (f % 2);
      w = cm_m[nxt];
      md = w[15:13];
      st = int'(w[8 +: SW]);
      sc = int'(w[0 +: CW]);
      bank = (md[0] == 1'b0 && sc < nxt) ? op : 1 - op;
      eoe = 1'b1; eb = 8'hFF;
      pb = '0;
      for (int i = 0; i < 8; i++) begin
         nb = lf[14] ^ lf[13];
         pb[7 - i] = nb;
         if (md == 3'b101) lf = {lf[13:0], nb};
      end
      case (md)
         3'b000: begin eb = lm[bank][st][sc]; tag = (sc == nxt - 1) ? "R11 R3" : "R3 R1"; end
         3'b001: begin eb = lm[bank][st][sc]; tag = "R4 R1"; end
         3'b010: begin eb = bm[bank][st][sc]; tag = (sc == nxt - 1) ? "R11 R5" : "R5"; end
         3'b011: begin eb = bm[bank][st][sc]; tag = "R5"; end
         3'b100: begin eb = w[7:0]; tag = "R6"; end
         3'b101: begin eb = pb; tag = pat_fresh ? "R8" : "R7"; pat_fresh = 1'b0; end
         default: begin eoe = 1'b0; tag = "R9"; end
      endcase
      if (fs && pclr) begin
         lf = '1;
         pat_fresh = 1'b1;
      end
      if (f == 0) tag = {tag, " R2"};
      if (nxt == 0) tag = {tag, " R10"};
      if (xtag != "") tag = {tag, " ", xtag};
      e.oe = eoe; e.d = eb; e.tag = tag; e.due = cyc + 1;
      sb.push_back(e);
      // R12: the table write takes effect after this cycle's read
      if (cwe) cm_m[caddr] = cdat;
   endtask

   initial begin : watchdog
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      for (int k = 0; k < CH; k++) cm_m[k] = 16'hC000;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R2 reset", tx_oe, tx_data, 1'b0, 8'hFF);
      @(posedge clk);
      #1 rst_n = 1'b1;
      for (int f = 0; f < NFRAMES; f++) begin
         for (int c = 0; c < CH; c++) begin
            bit cwe;
            int ca;
            logic [15:0] cd;
            string xt;
            cwe = 1'b0; ca = 0; cd = '0; xt = "";
            if (f == 1) begin
               cwe = 1'b1; ca = c; cd = cm_word(c);
            end
            if (f == 4 && c == 10) begin
               cwe = 1'b1; ca = 11; cd = {3'b100, 5'd0, 8'h5A}; xt = "R12";
            end
            if (f == 5 && c == 10) xt = "R12";
            drive_cycle(f, c, c == 0, f == 3 && c == 0, cwe, ca, cd, xt);
         end
      end
      @(posedge clk);
      #1;
      loc_we = 1'b0; bp_we = 1'b0; cm_we = 1'b0; frame_sync = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL R10: got %0d pending results, expected 0", sb.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule